// File: doc/BRIEF.md
# Sampled-Clock Flip-Flop Emulator

This block models a storage element that has a data clock, an asynchronous force-high, an asynchronous force-low and an asynchronous parallel load. It runs entirely on one fast global clock. The data clock and every control and data input are plain signals that the block samples on each global edge. The output is worked out in two ordered stages from a set of sampled copies.

The first stage starts from the previous output and applies every update that is due to sampled values. These are a data-clock rising edge, or a control that was active in the previous global cycle. The second stage applies every update that is due to current input values, and it overrides the first. A control therefore keeps acting for one global cycle after it drops, which models a negative hold time. A control that is active now shows at the output in the same global cycle.

Each global cycle the resolver picks one winning source, held in an enumerated selector, and the output process drives the value that source implies. The sources, from lowest to highest precedence, are:
- `SRC_HOLD`: keep the previous output.
- `SRC_EDGE`: take the data sampled before the edge.
- `SRC_PLD`: take the load value sampled while the load was high.
- `SRC_PHI`: the force-high that was active last cycle.
- `SRC_PLO`: the force-low that was active last cycle.
- `SRC_LD`: the current load value.
- `SRC_HI`: the current force-high.
- `SRC_LO`: the current force-low.

The choice moves to a higher source whenever that source's condition holds.

Top module: `ffemu_top`

## Requirements
- R1: While `rst_n` is low, every sampled copy takes a defined value: clock 1, controls 0, data 0, previous output 0. In the first global cycle after reset, with no control active, `qout` is 0 and a high `data_clk` is not taken as a rising edge.
- R2: A rising data clock loads `qout` with the `din` sampled in the previous global cycle. This happens when `data_clk` was 0 in the previous global cycle and is 1 now, and no control is active now or was active then. With no edge and no control, `qout` holds its value.
- R3: While `force_lo` is 1, `qout` is all zeros in the same global cycle, whatever the other inputs are.
- R4: While `force_hi` is 1 and `force_lo` is 0, `qout` is all ones in the same global cycle.
- R5: While `load_en` is 1 and neither force is active, `qout` equals the current `load_val`.
- R6: In the cycle where `load_en` falls, with no force active now or before, `qout` takes the `load_val` sampled in the previous cycle, not the new `load_val`.
- R7: When `force_lo` falls in the same cycle that `force_hi` rises, `qout` is all ones in that very cycle.
- R8: A control that was active in the previous global cycle still acts in the cycle after it drops. A sampled force-low beats a data-clock edge in that cycle, and a sampled force-high keeps `qout` all ones.
- R9: Current controls override sampled ones. A force-low that rises as force-high falls gives zeros, and a force-high that rises as the load falls gives ones.
- R10: A `din` change in the same cycle as the data-clock rise is not captured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| gclk | input | 1 | Global sampling clock |
| rst_n | input | 1 | Active-low reset of sampled copies |
| data_clk | input | 1 | Emulated data clock, sampled |
| force_hi | input | 1 | Asynchronous force to all ones |
| force_lo | input | 1 | Asynchronous force to all zeros |
| load_en | input | 1 | Asynchronous parallel load enable |
| load_val | input | WIDTH | Value for asynchronous load |
| din | input | WIDTH | Data captured on data-clock edge |
| qout | output | WIDTH | Emulated flip-flop output |

## Verification
The risky overlaps are a falling load with a changing load value, and a falling force-low with a rising force-high. In both cases a sampled update and a current update land in the same global cycle. A fixed vector table provokes each overlap directly, with the expected output worked out from the precedence rules. A pseudo-random run then toggles controls and data together and compares every cycle against a layered reference model in the bench.

// File: rtl/ffemu_pkg.sv
package ffemu_pkg;
    typedef enum logic [2:0] {
        SRC_HOLD = 3'd0,
        SRC_EDGE = 3'd1,
        SRC_PLD  = 3'd2,
        SRC_PHI  = 3'd3,
        SRC_PLO  = 3'd4,
        SRC_LD   = 3'd5,
        SRC_HI   = 3'd6,
        SRC_LO   = 3'd7
    } upd_src_e;
endpackage

// File: rtl/ffemu_sampler.sv
module ffemu_sampler #(
    parameter int WIDTH = 8
) (
    input  logic             gclk,
    input  logic             rst_n,
    input  logic             data_clk,
    input  logic             force_hi,
    input  logic             force_lo,
    input  logic             load_en,
    input  logic [WIDTH-1:0] load_val,
    input  logic [WIDTH-1:0] din,
    input  logic [WIDTH-1:0] q_now,
    output logic             clk_s,
    output logic             hi_s,
    output logic             lo_s,
    output logic             ld_s,
    output logic [WIDTH-1:0] ldv_s,
    output logic [WIDTH-1:0] din_s,
    output logic [WIDTH-1:0] q_s
);
    // R1: defined reset values; clock copy at 1 so no edge is seen first
    always_ff @(posedge gclk or negedge rst_n) begin
        if (!rst_n) begin
            clk_s <= 1'b1;
            hi_s  <= 1'b0;
            lo_s  <= 1'b0;
            ld_s  <= 1'b0;
            ldv_s <= '0;
            din_s <= '0;
            q_s   <= '0;
        end else begin
            clk_s <= data_clk;
            hi_s  <= force_hi;
            lo_s  <= force_lo;
            ld_s  <= load_en;
            ldv_s <= load_val;
            din_s <= din;
            q_s   <= q_now;
        end
    end

    assert_reset_idle_R1: assert property (@(posedge gclk)
        !rst_n |=> (clk_s && !hi_s && !lo_s && !ld_s && q_s == '0));
endmodule

// File: rtl/ffemu_resolver.sv
module ffemu_resolver
    import ffemu_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             data_clk,
    input  logic             force_hi,
    input  logic             force_lo,
    input  logic             load_en,
    input  logic [WIDTH-1:0] load_val,
    input  logic             clk_s,
    input  logic             hi_s,
    input  logic             lo_s,
    input  logic             ld_s,
    input  logic [WIDTH-1:0] ldv_s,
    input  logic [WIDTH-1:0] din_s,
    input  logic [WIDTH-1:0] q_s,
    output logic [WIDTH-1:0] q_res
);
    upd_src_e src;
    logic     rise;

    assign rise = !clk_s && data_clk;

    // selection: current controls first, then sampled ones, then the edge
    always_comb begin
        if (force_lo)      src = SRC_LO;
        else if (force_hi) src = SRC_HI;
        else if (load_en)  src = SRC_LD;
        else if (lo_s)     src = SRC_PLO;
        else if (hi_s)     src = SRC_PHI;
        else if (ld_s)     src = SRC_PLD;
        else if (rise)     src = SRC_EDGE;
        else               src = SRC_HOLD;
    end

    always_comb begin
        unique case (src)
            SRC_LO:   q_res = '0;
            SRC_HI:   q_res = '1;
            SRC_LD:   q_res = load_val;
            SRC_PLO:  q_res = '0;
            SRC_PHI:  q_res = '1;
            SRC_PLD:  q_res = ldv_s;
            SRC_EDGE: q_res = din_s;
            SRC_HOLD: q_res = q_s;
            default:  q_res = q_s;
        endcase
    end
endmodule

// File: rtl/ffemu_top.sv
module ffemu_top #(
    parameter int WIDTH = 8
) (
    input  logic             gclk,
    input  logic             rst_n,
    input  logic             data_clk,
    input  logic             force_hi,
    input  logic             force_lo,
    input  logic             load_en,
    input  logic [WIDTH-1:0] load_val,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] qout
);
    logic             clk_s, hi_s, lo_s, ld_s;
    logic [WIDTH-1:0] ldv_s, din_s, q_s;

    ffemu_sampler #(.WIDTH(WIDTH)) u_sampler (
        .gclk(gclk), .rst_n(rst_n), .data_clk(data_clk),
        .force_hi(force_hi), .force_lo(force_lo), .load_en(load_en),
        .load_val(load_val), .din(din), .q_now(qout),
        .clk_s(clk_s), .hi_s(hi_s), .lo_s(lo_s), .ld_s(ld_s),
        .ldv_s(ldv_s), .din_s(din_s), .q_s(q_s)
    );

    ffemu_resolver #(.WIDTH(WIDTH)) u_resolver (
        .data_clk(data_clk), .force_hi(force_hi), .force_lo(force_lo),
        .load_en(load_en), .load_val(load_val),
        .clk_s(clk_s), .hi_s(hi_s), .lo_s(lo_s), .ld_s(ld_s),
        .ldv_s(ldv_s), .din_s(din_s), .q_s(q_s), .q_res(qout)
    );

    assert_lo_zero_R3: assert property (@(posedge gclk) disable iff (!rst_n)
        force_lo |-> qout == '0);

    assert_hi_ones_R4: assert property (@(posedge gclk) disable iff (!rst_n)
        (force_hi && !force_lo) |-> qout == '1);

    assert_load_follow_R5: assert property (@(posedge gclk) disable iff (!rst_n)
        (load_en && !force_hi && !force_lo) |-> qout == load_val);

    assert_load_fall_R6: assert property (@(posedge gclk) disable iff (!rst_n)
        ($past(rst_n) && $fell(load_en) && !force_hi && !force_lo
         && !$past(force_hi) && !$past(force_lo)) |-> qout == $past(load_val));

    assert_lo_fall_hi_rise_R7: assert property (@(posedge gclk) disable iff (!rst_n)
        ($past(rst_n) && $fell(force_lo) && $rose(force_hi)) |-> qout == '1);

    assert_edge_capture_R2: assert property (@(posedge gclk) disable iff (!rst_n)
        ($past(rst_n) && $rose(data_clk) && !force_hi && !force_lo && !load_en
         && !$past(force_hi) && !$past(force_lo) && !$past(load_en))
        |-> qout == $past(din));

    assert_hold_R2: assert property (@(posedge gclk) disable iff (!rst_n)
        ($past(rst_n) && !$rose(data_clk) && !force_hi && !force_lo && !load_en
         && !$past(force_hi) && !$past(force_lo) && !$past(load_en))
        |-> qout == $past(qout));
endmodule

// File: tb/ffemu_top_bench.sv
module ffemu_top_bench;
    localparam int PER = 10;
    localparam int W   = 8;
    localparam int NV  = 19;

    // vector: {data_clk, force_hi, force_lo, load_en, load_val, din, expected}
    typedef logic [4+3*W-1:0] vec_t;
    localparam vec_t TBL [NV] = '{
        {4'b1000, 8'h00, 8'hA5, 8'h00},  // 0  R1 no edge after reset
        {4'b0000, 8'h00, 8'h3C, 8'h00},  // 1  R2 hold
        {4'b1000, 8'h00, 8'hC3, 8'h3C},  // 2  R2 R10 edge takes old din
        {4'b1000, 8'h00, 8'hFF, 8'h3C},  // 3  R2 no edge, hold
        {4'b0010, 8'h00, 8'hFF, 8'h00},  // 4  R3
        {4'b0100, 8'h00, 8'hFF, 8'hFF},  // 5  R7 lo falls, hi rises
        {4'b0000, 8'h00, 8'hFF, 8'hFF},  // 6  R8 sampled hi
        {4'b0000, 8'h00, 8'hFF, 8'hFF},  // 7  R2 hold
        {4'b0001, 8'h5A, 8'h00, 8'h5A},  // 8  R5
        {4'b0001, 8'h96, 8'h00, 8'h96},  // 9  R5 follows
        {4'b0000, 8'h11, 8'h00, 8'h96},  // 10 R6 load falls
        {4'b0000, 8'h22, 8'h00, 8'h96},  // 11 R2 hold
        {4'b0100, 8'h00, 8'h00, 8'hFF},  // 12 R4
        {4'b0010, 8'h00, 8'h77, 8'h00},  // 13 R9 lo rises, hi falls
        {4'b1000, 8'h00, 8'h77, 8'h00},  // 14 R8 sampled lo beats edge
        {4'b0000, 8'h00, 8'h81, 8'h00},  // 15 R2 hold
        {4'b1000, 8'h00, 8'hEE, 8'h81},  // 16 R10 edge takes 81
        {4'b0001, 8'h44, 8'h00, 8'h44},  // 17 R5
        {4'b0100, 8'h55, 8'h00, 8'hFF}   // 18 R9 hi beats sampled load
    };

    logic         gclk = 1'b0;
    logic         rst_n = 1'b0;
    logic         data_clk = 1'b0, force_hi = 1'b0, force_lo = 1'b0, load_en = 1'b0;
    logic [W-1:0] load_val = '0, din = '0;
    logic [W-1:0] qout;

    int n_cmp = 0;
    int n_bad = 0;

    // reference model state
    logic         m_clk = 1'b1, m_hi = 1'b0, m_lo = 1'b0, m_ld = 1'b0;
    logic [W-1:0] m_ldv = '0, m_din = '0, m_q = '0;

    ffemu_top #(.WIDTH(W)) u_ffemu_top (
        .gclk(gclk), .rst_n(rst_n), .data_clk(data_clk),
        .force_hi(force_hi), .force_lo(force_lo), .load_en(load_en),
        .load_val(load_val), .din(din), .qout(qout)
    );

    always #(PER/2) gclk = ~gclk;

    function automatic logic [W-1:0] model_out();
        logic [W-1:0] v;
        v = m_q;
        if (!m_clk && data_clk) v = m_din;
        if (m_ld) v = m_ldv;
        if (m_hi) v = '1;
        if (m_lo) v = '0;
        if (load_en) v = load_val;
        if (force_hi) v = '1;
        if (force_lo) v = '0;
        return v;
    endfunction

    task automatic model_reset();
        m_clk = 1'b1; m_hi = 1'b0; m_lo = 1'b0; m_ld = 1'b0;
        m_ldv = '0; m_din = '0; m_q = '0;
    endtask

    task automatic model_advance(input logic [W-1:0] qv);
        m_clk = data_clk; m_hi = force_hi; m_lo = force_lo; m_ld = load_en;
        m_ldv = load_val; m_din = din; m_q = qv;
    endtask

    task automatic check(input string req, input logic [W-1:0] exp);
        n_cmp++;
        if (qout !== exp) begin
            n_bad++;
            $display("FAIL %s: qout=%h expected=%h at %0t", req, qout, exp, $time);
        end
    endtask

    task automatic drive(input logic c, input logic h, input logic l, input logic e,
                         input logic [W-1:0] lv, input logic [W-1:0] d);
        @(negedge gclk);
        data_clk = c; force_hi = h; force_lo = l; load_en = e;
        load_val = lv; din = d;
        #(PER/2 - 1);
    endtask

    initial begin
        #(PER * 100000);
        n_bad++;
        $display("FAIL watchdog: run did not complete");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [W-1:0] e;
        // reset phase, R1
        repeat (3) @(negedge gclk);
        check("R1", 8'h00);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            vec_t v;
            v = TBL[i];
            drive(v[27], v[26], v[25], v[24], v[23:16], v[15:8]);
            check($sformatf("R-table step %0d", i), v[7:0]);
            e = model_out();
            check("R2 model agreement", e);
            model_advance(e);
        end

        // R1: reset again with data_clk high during and after reset
        @(negedge gclk);
        rst_n = 1'b0; data_clk = 1'b1; force_hi = 1'b0; force_lo = 1'b0; load_en = 1'b0;
        din = 8'h5D; load_val = 8'h00;
        repeat (2) @(negedge gclk);
        rst_n = 1'b1;
        model_reset();
        #(PER/2 - 1);
        check("R1 no spurious edge", 8'h00);
        model_advance(8'h00);

        // R7 corner again from a zero state: lo held, then swaps to hi
        drive(1'b0, 1'b0, 1'b1, 1'b0, 8'h00, 8'h00);
        check("R3", 8'h00);
        model_advance(8'h00);
        drive(1'b0, 1'b1, 1'b0, 1'b0, 8'h00, 8'h00);
        check("R7", 8'hFF);
        model_advance(8'hFF);
        // R6: load high with value, then drop while value changes
        drive(1'b0, 1'b0, 1'b0, 1'b1, 8'h3E, 8'h00);
        check("R5", 8'h3E);
        model_advance(8'h3E);
        drive(1'b0, 1'b0, 1'b0, 1'b0, 8'hC1, 8'h00);
        check("R6", 8'h3E);
        model_advance(8'h3E);

        // pseudo-random overlap run against the model, R6 R7 R8 R9
        for (int k = 0; k < 400; k++) begin
            logic [31:0] r;
            r = $urandom;
            drive(r[0], (r[3:1] == 3'd0), (r[6:4] == 3'd0), (r[9:7] < 3'd2),
                  r[17:10], r[25:18]);
            e = model_out();
            check("R9 random overlap vs model", e);
            model_advance(e);
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule